// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder

This block turns write cycles on an asynchronous-style memory bus (chip enable, write enable, output enable, an address bus and a byte-wide data bus, all sampled on the system clock) into instruction strobes for a program/erase controller. A write cycle is one stretch in which chip enable and write enable are both low while output enable is high. The address is taken when that stretch begins, which is when the later of the two enables falls. The data is taken from the last sampled cycle before the stretch ends, which is when the earlier of the two enables rises.

Program and erase are guarded by a coded handshake. Every instruction opens with two unlock writes, 0xAA to word 0x555 and then 0x55 to word 0x2AA, followed by a set-up write to 0x555. Program then takes one more write that carries the target address and data. Erase repeats the unlock pair and then takes a confirm write. A write that does not fit the expected position in the sequence abandons it and produces a return-to-read strobe. Suspend and resume are single writes that are accepted only in a matching erase state. Further block-erase confirms are accepted without a new handshake while a restartable timeout window stays open.

Each accepted instruction appears as a one-cycle `ins_valid` pulse with a 3-bit code and the address and data of the write that completed it.

Top module: `flcmd_decoder`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `ins_valid` is 0 and the decoder waits for the first unlock write.
- R2: A write cycle is a period of `ce_n`=0, `we_n`=0, `oe_n`=1. Its address is the one sampled in its first active cycle and its data is the one sampled in its last active cycle. The resulting strobe (if any) is high in the second clock cycle after the first cycle in which the write condition is no longer seen. A period with `oe_n`=0 is not a write.
- R3: The writes 0xAA@0x555, 0x55@0x2AA and 0xA0@0x555, followed by any write, give code 3 (program) carrying that fourth write's address and data.
- R4: After the unlock pair, a set-up write of 0x90@0x555 gives code 2 (auto select) and 0xF0@0x555 gives code 1 (read array).
- R5: Unlock pair, 0x80@0x555, unlock pair again, then 0x10@0x555 gives code 5 (chip erase). A 0x10 confirm at any other address gives code 1.
- R6: The same erase preamble closed by 0x30 at any address gives code 4 (block erase) carrying that address.
- R7: A 0x30 write whose strobe would fall no more than WIN_CYC cycles after the previous block-erase strobe gives a further code 4 and restarts the window. Any other write closes the window. A 0x30 arriving later is not added.
- R8: Any write that does not match the expected data and, for coded, set-up and chip-confirm cycles, the expected low 11 address bits, gives code 1 and returns the decoder to the first unlock position.
- R9: Outside a sequence, 0xB0 gives code 6 (suspend) only while an erase runs, and 0x30 gives code 7 (resume) only while an erase is suspended. Otherwise either one gives code 1.
- R10: A pulse on `erase_done` ends the erase state, after which 0xB0 and 0x30 give code 1.
- R11: `supply_low` returns the decoder to the first unlock position, clears the erase state and the window, and issues no strobe.
- R12: `ins_valid` lasts one cycle, carries a nonzero code, and occurs at most once per write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_low | input | 1 | Supply-low indication, resets the sequence |
| erase_done | input | 1 | Pulse from the controller when an erase completes |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Bus address |
| dq_in | input | 8 | Bus write data |
| ins_valid | output | 1 | One-cycle instruction strobe |
| ins_code | output | 3 | Instruction code (1 read, 2 auto select, 3 program, 4 block erase, 5 chip erase, 6 suspend, 7 resume) |
| ins_addr | output | AW | Address of the write that completed the instruction |
| ins_data | output | 8 | Data of the write that completed the instruction |

## Verification
Every strobe is due exactly two clock edges after the first edge at which the write condition is seen to have ended: one edge registers the write end and one registers the decision. The bench's behavioural model files each expected strobe under that due cycle and, on every falling clock edge, requires either the queued strobe or a quiet `ins_valid`. The block-erase window is checked in the same terms. A further 0x30 is accepted when its due cycle lies at most WIN_CYC cycles after the previous block-erase strobe, so the bench places one confirm exactly on that bound and another one cycle past it.

// File: rtl/flcmd_pkg.sv
// Shared types and code points for the unlock-sequence command decoder.
// Assumes a byte-wide data bus and at least 11 address bits for the coded words.
package flcmd_pkg;

    typedef enum logic [2:0] {
        INS_NONE   = 3'd0,
        INS_READ   = 3'd1,
        INS_ASEL   = 3'd2,
        INS_PROG   = 3'd3,
        INS_BERASE = 3'd4,
        INS_CERASE = 3'd5,
        INS_SUSP   = 3'd6,
        INS_RESUME = 3'd7
    } ins_e;

    typedef enum logic [1:0] {
        ER_IDLE = 2'd0,
        ER_RUN  = 2'd1,
        ER_HOLD = 2'd2
    } er_e;

    typedef enum logic [2:0] {
        SQ_UNLK_A = 3'd0,
        SQ_UNLK_B = 3'd1,
        SQ_SETUP  = 3'd2,
        SQ_PDATA  = 3'd3,
        SQ_ERS_A  = 3'd4,
        SQ_ERS_B  = 3'd5,
        SQ_CONF   = 3'd6
    } sq_e;

    localparam int          CODE_AW  = 11;
    localparam logic [10:0] W_UNLK_A = 11'h555;
    localparam logic [10:0] W_UNLK_B = 11'h2AA;
    localparam logic [7:0]  B_UNLK_A = 8'hAA;
    localparam logic [7:0]  B_UNLK_B = 8'h55;
    localparam logic [7:0]  B_READ   = 8'hF0;
    localparam logic [7:0]  B_ASEL   = 8'h90;
    localparam logic [7:0]  B_PROG   = 8'hA0;
    localparam logic [7:0]  B_ERASE  = 8'h80;
    localparam logic [7:0]  B_CHIP   = 8'h10;
    localparam logic [7:0]  B_BLOCK  = 8'h30;
    localparam logic [7:0]  B_SUSP   = 8'hB0;
    localparam logic [7:0]  B_RESUME = 8'h30;

endpackage

// File: rtl/flcmd_bus_capture.sv
// Bus write capture: detects a write period (ce_n low, we_n low, oe_n high)
// in the clock domain and latches address at its start, data at its end.
// Assumes the bus pins are already synchronous to clk.
module flcmd_bus_capture #(
    parameter int AW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    dq_in,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);

    logic act;
    logic act_q;

    // Write condition: both enables low with outputs disabled.
    assign act = !ce_n && !we_n && oe_n;

    // Track write edges, latch address on entry and data on every active cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            act_q  <= act;
            wr_stb <= act_q && !act;
            if (act && !act_q) begin
                wr_addr <= addr;
            end
            if (act) begin
                wr_data <= dq_in;
            end
        end
    end

endmodule

// File: rtl/flcmd_win_timer.sv
// Restartable window timer for additional block-erase confirms.
// After a load the window stays open for WIN_CYC further clock edges.
// Assumes WIN_CYC >= 1.
module flcmd_win_timer #(
    parameter int WIN_CYC = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    output logic win_open
);

    localparam int TW = $clog2(WIN_CYC + 1);

    logic [TW-1:0] cnt;

    // Load, count down, close on expiry or explicit clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            win_open <= 1'b0;
            cnt      <= '0;
        end else if (load) begin
            win_open <= 1'b1;
            cnt      <= TW'(WIN_CYC - 1);
        end else if (win_open) begin
            if (cnt == '0) begin
                win_open <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/flcmd_erase_track.sv
// Erase state tracker: follows issued strobes and the controller's done pulse.
// A new strobe in the same cycle as erase_done takes priority.
module flcmd_erase_track (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ins_valid,
    input  flcmd_pkg::ins_e   ins_code,
    input  logic              erase_done,
    output flcmd_pkg::er_e    er_st
);

    import flcmd_pkg::*;

    // Running after an erase or resume, held after suspend, idle when done.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            er_st <= ER_IDLE;
        end else if (ins_valid && (ins_code == INS_BERASE || ins_code == INS_CERASE
                                   || ins_code == INS_RESUME)) begin
            er_st <= ER_RUN;
        end else if (ins_valid && ins_code == INS_SUSP) begin
            er_st <= ER_HOLD;
        end else if (erase_done) begin
            er_st <= ER_IDLE;
        end
    end

endmodule

// File: rtl/flcmd_seq.sv
// Cycle-sequence tracker: checks each captured write against its expected
// position in the coded handshake and issues one-cycle instruction strobes.
// Assumes AW >= 11; only the low 11 address bits are compared.
module flcmd_seq #(
    parameter int AW = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vlow,
    input  logic              wr_stb,
    input  logic [AW-1:0]     wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              win_open,
    input  flcmd_pkg::er_e    er_st,
    output logic              ins_valid,
    output flcmd_pkg::ins_e   ins_code,
    output logic [AW-1:0]     ins_addr,
    output logic [7:0]        ins_data,
    output logic              win_load,
    output logic              win_clr
);

    import flcmd_pkg::*;

    sq_e                 sq;
    sq_e                 sq_n;
    ins_e                code_n;
    logic                ld_n;
    logic [CODE_AW-1:0]  wa;
    logic                hit_a;
    logic                hit_b;

    assign wa    = wr_addr[CODE_AW-1:0];
    assign hit_a = (wa == W_UNLK_A) && (wr_data == B_UNLK_A);
    assign hit_b = (wa == W_UNLK_B) && (wr_data == B_UNLK_B);

    // Next position and strobe decision for the current write.
    always_comb begin
        sq_n   = sq;
        code_n = INS_NONE;
        ld_n   = 1'b0;
        if (wr_stb) begin
            case (sq)
                SQ_UNLK_A: begin
                    if (win_open && wr_data == B_BLOCK) begin
                        code_n = INS_BERASE;
                        ld_n   = 1'b1;
                    end else if (hit_a) begin
                        sq_n = SQ_UNLK_B;
                    end else if (wr_data == B_SUSP && er_st == ER_RUN) begin
                        code_n = INS_SUSP;
                    end else if (wr_data == B_RESUME && er_st == ER_HOLD) begin
                        code_n = INS_RESUME;
                    end else begin
                        code_n = INS_READ;
                    end
                end
                SQ_UNLK_B: begin
                    if (hit_b) begin
                        sq_n = SQ_SETUP;
                    end else begin
                        sq_n   = SQ_UNLK_A;
                        code_n = INS_READ;
                    end
                end
                SQ_SETUP: begin
                    sq_n   = SQ_UNLK_A;
                    code_n = INS_READ;
                    if (wa == W_UNLK_A) begin
                        case (wr_data)
                            B_ASEL:  code_n = INS_ASEL;
                            B_PROG:  begin sq_n = SQ_PDATA; code_n = INS_NONE; end
                            B_ERASE: begin sq_n = SQ_ERS_A; code_n = INS_NONE; end
                            default: code_n = INS_READ;
                        endcase
                    end
                end
                SQ_PDATA: begin
                    sq_n   = SQ_UNLK_A;
                    code_n = INS_PROG;
                end
                SQ_ERS_A: begin
                    if (hit_a) begin
                        sq_n = SQ_ERS_B;
                    end else begin
                        sq_n   = SQ_UNLK_A;
                        code_n = INS_READ;
                    end
                end
                SQ_ERS_B: begin
                    if (hit_b) begin
                        sq_n = SQ_CONF;
                    end else begin
                        sq_n   = SQ_UNLK_A;
                        code_n = INS_READ;
                    end
                end
                SQ_CONF: begin
                    sq_n = SQ_UNLK_A;
                    if (wr_data == B_BLOCK) begin
                        code_n = INS_BERASE;
                        ld_n   = 1'b1;
                    end else if (wr_data == B_CHIP && wa == W_UNLK_A) begin
                        code_n = INS_CERASE;
                    end else begin
                        code_n = INS_READ;
                    end
                end
                default: begin
                    sq_n   = SQ_UNLK_A;
                    code_n = INS_READ;
                end
            endcase
        end
    end

    // Window control: open on a block confirm, close on any other write or low supply.
    assign win_load = ld_n;
    assign win_clr  = vlow || (wr_stb && !ld_n);

    // Register position and strobe outputs.
    always_ff @(posedge clk) begin
        if (!rst_n || vlow) begin
            sq        <= SQ_UNLK_A;
            ins_valid <= 1'b0;
            ins_code  <= INS_NONE;
            ins_addr  <= '0;
            ins_data  <= '0;
        end else begin
            sq        <= sq_n;
            ins_valid <= (code_n != INS_NONE);
            ins_code  <= code_n;
            if (code_n != INS_NONE) begin
                ins_addr <= wr_addr;
                ins_data <= wr_data;
            end
        end
    end

endmodule

// File: rtl/flcmd_decoder.sv
// Top of the unlock-sequence command decoder. Joins the bus capture, the
// sequence tracker, the erase state tracker and the confirm window timer.
// Assumes bus pins synchronous to clk and AW >= 11.
module flcmd_decoder #(
    parameter int AW      = 19,
    parameter int WIN_CYC = 2500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_low,
    input  logic          erase_done,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    dq_in,
    output logic          ins_valid,
    output logic [2:0]    ins_code,
    output logic [AW-1:0] ins_addr,
    output logic [7:0]    ins_data
);

    import flcmd_pkg::*;

    logic          wr_stb;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          win_open;
    logic          win_load;
    logic          win_clr;
    er_e           er_st;
    ins_e          ins_q;

    flcmd_bus_capture #(.AW(AW)) cap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .addr    (addr),
        .dq_in   (dq_in),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    flcmd_seq #(.AW(AW)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .vlow      (supply_low),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .win_open  (win_open),
        .er_st     (er_st),
        .ins_valid (ins_valid),
        .ins_code  (ins_q),
        .ins_addr  (ins_addr),
        .ins_data  (ins_data),
        .win_load  (win_load),
        .win_clr   (win_clr)
    );

    flcmd_erase_track ers_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (supply_low),
        .ins_valid  (ins_valid),
        .ins_code   (ins_q),
        .erase_done (erase_done),
        .er_st      (er_st)
    );

    flcmd_win_timer #(.WIN_CYC(WIN_CYC)) win_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (win_clr),
        .load     (win_load),
        .win_open (win_open)
    );

    assign ins_code = ins_q;

endmodule

// File: rtl/flcmd_decoder_chk.sv
// Protocol checker for the command decoder, attached by bind. Keeps its own
// view of the erase state, derived from strobes and the done pulse.
module flcmd_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_low,
    input logic       erase_done,
    input logic       ce_n,
    input logic       we_n,
    input logic       oe_n,
    input logic       ins_valid,
    input logic [2:0] ins_code
);

    logic act;
    logic run_f;
    logic hold_f;

    assign act = !ce_n && !we_n && oe_n;

    // Erase state as seen from the strobe stream.
    always_ff @(posedge clk) begin
        if (!rst_n || supply_low) begin
            run_f  <= 1'b0;
            hold_f <= 1'b0;
        end else if (ins_valid && (ins_code == 3'd4 || ins_code == 3'd5 || ins_code == 3'd7)) begin
            run_f  <= 1'b1;
            hold_f <= 1'b0;
        end else if (ins_valid && ins_code == 3'd6) begin
            run_f  <= 1'b0;
            hold_f <= 1'b1;
        end else if (erase_done) begin
            run_f  <= 1'b0;
            hold_f <= 1'b0;
        end
    end

    // R1: no strobe on the first cycle after reset release.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !ins_valid);

    // R2: a strobe follows a write that ended two edges earlier.
    p_strobe_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> ($past(act, 3) && !$past(act, 2)));

    // R9: suspend only while running, resume only while held.
    p_suspend_needs_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_code == 3'd6) |-> $past(run_f));

    p_resume_needs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_code == 3'd7) |-> $past(hold_f));

    // R11: low supply silences the next cycle.
    p_quiet_after_lowv_r11: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> !ins_valid);

    // R12: one-cycle strobe with a real code.
    p_strobe_one_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |=> !ins_valid);

    p_strobe_code_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> (ins_code != 3'd0));

endmodule

bind flcmd_decoder flcmd_decoder_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_low (supply_low),
    .erase_done (erase_done),
    .ce_n       (ce_n),
    .we_n       (we_n),
    .oe_n       (oe_n),
    .ins_valid  (ins_valid),
    .ins_code   (ins_code)
);

// File: tb/flcmd_decoder_tb_top.sv
// Bench for the command decoder: a behavioural model queues each expected
// strobe with its due cycle; every cycle is compared at the falling edge.
module flcmd_decoder_tb_top;

    localparam int AW  = 19;
    localparam int WIN = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          supply_low = 1'b0;
    logic          erase_done = 1'b0;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    dq_in = '0;
    logic          ins_valid;
    logic [2:0]    ins_code;
    logic [AW-1:0] ins_addr;
    logic [7:0]    ins_data;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    bit chk_on  = 0;

    int    q_due[$];
    int    q_code[$];
    int    q_addr[$];
    int    q_data[$];
    string q_tag[$];

    int m_sq = 0;
    int m_er = 0;
    bit m_win = 0;
    int m_last_be = 0;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    flcmd_decoder #(.AW(AW), .WIN_CYC(WIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .erase_done(erase_done),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
        .ins_valid(ins_valid), .ins_code(ins_code), .ins_addr(ins_addr), .ins_data(ins_data)
    );

    // Behavioural expectation for one completed write.
    task automatic model_write(input int a, input int d, input int due, input string tag);
        int  w;
        int  code;
        bit  ld;
        w = a & 'h7FF;
        code = 0;
        ld = 0;
        case (m_sq)
            0: begin
                if (m_win && (due - m_last_be) <= WIN && d == 'h30) begin code = 4; ld = 1; end
                else if (w == 'h555 && d == 'hAA) m_sq = 1;
                else if (d == 'hB0 && m_er == 1) code = 6;
                else if (d == 'h30 && m_er == 2) code = 7;
                else code = 1;
            end
            1: if (w == 'h2AA && d == 'h55) m_sq = 2; else begin m_sq = 0; code = 1; end
            2: begin
                m_sq = 0;
                if (w != 'h555) code = 1;
                else if (d == 'h90) code = 2;
                else if (d == 'hA0) m_sq = 3;
                else if (d == 'h80) m_sq = 4;
                else code = 1;
            end
            3: begin m_sq = 0; code = 3; end
            4: if (w == 'h555 && d == 'hAA) m_sq = 5; else begin m_sq = 0; code = 1; end
            5: if (w == 'h2AA && d == 'h55) m_sq = 6; else begin m_sq = 0; code = 1; end
            default: begin
                m_sq = 0;
                if (d == 'h30) begin code = 4; ld = 1; end
                else if (d == 'h10 && w == 'h555) code = 5;
                else code = 1;
            end
        endcase
        m_win = ld;
        if (ld) m_last_be = due;
        if (code == 4 || code == 5 || code == 7) m_er = 1;
        if (code == 6) m_er = 2;
        if (code != 0) begin
            q_due.push_back(due);
            q_code.push_back(code);
            q_addr.push_back(a);
            q_data.push_back(d);
            q_tag.push_back(tag);
        end
    endtask

    // Plain write: both enables low together for two cycles.
    task automatic bus_write(input int a, input int d, input string tag);
        @(negedge clk);
        addr = AW'(a); dq_in = 8'(d); oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        model_write(a, d, cyc + 2, tag);
        @(negedge clk);
        @(negedge clk);
    endtask

    // Skewed write: we_n falls first, ce_n falls later and rises first;
    // address and data change inside the active period.
    task automatic bus_write_skew(input int a, input int a_late, input int d_early,
                                  input int d, input string tag);
        @(negedge clk);
        addr = AW'(a_late); we_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        addr = AW'(a); dq_in = 8'(d_early); ce_n = 1'b0;
        @(negedge clk);
        addr = AW'(a_late); dq_in = 8'(d);
        @(negedge clk);
        ce_n = 1'b1;
        model_write(a, d, cyc + 2, tag);
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
    endtask

    // Enables low with outputs on: must not count as a write.
    task automatic bus_read_pulse(input int a, input int d);
        @(negedge clk);
        addr = AW'(a); dq_in = 8'(d); oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic unlock(input string tag);
        bus_write('h555, 'hAA, tag);
        bus_write('h2AA, 'h55, tag);
    endtask

    task automatic erase_pre(input string tag);
        unlock(tag);
        bus_write('h555, 'h80, tag);
        unlock(tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_done();
        @(negedge clk); erase_done = 1'b1;
        @(negedge clk); erase_done = 1'b0;
        m_er = 0;
        idle(2);
    endtask

    task automatic pulse_lowv();
        @(negedge clk); supply_low = 1'b1;
        @(negedge clk); supply_low = 1'b0;
        m_sq = 0; m_er = 0; m_win = 0;
        idle(2);
    endtask

    // Every-cycle comparison against the expected strobe queue.
    always @(negedge clk) begin
        if (chk_on) begin
            vectors++;
            if (q_due.size() > 0 && q_due[0] == cyc) begin
                if (!ins_valid || int'(ins_code) != q_code[0] || int'(ins_addr) != q_addr[0]
                    || int'(ins_data) != q_data[0]) begin
                    fails++;
                    $display("FAIL %s cyc %0d: valid=%0b code=%0d addr=%h data=%h, expected valid=1 code=%0d addr=%h data=%h",
                             q_tag[0], cyc, ins_valid, ins_code, ins_addr, ins_data,
                             q_code[0], q_addr[0], q_data[0]);
                end
                void'(q_due.pop_front());
                void'(q_code.pop_front());
                void'(q_addr.pop_front());
                void'(q_data.pop_front());
                void'(q_tag.pop_front());
            end else if (ins_valid) begin
                fails++;
                $display("FAIL R12 cyc %0d: unexpected strobe code=%0d, expected valid=0", cyc, ins_code);
            end
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        vectors++;
        if (ins_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: ins_valid=%0b after reset, expected 0", ins_valid);
        end
        chk_on = 1;

        // R3 program, plain and skewed fourth cycle (R2 capture points).
        unlock("R3");
        bus_write('h555, 'hA0, "R3");
        bus_write('h1234, 'h5A, "R3");
        unlock("R2");
        bus_write('h555, 'hA0, "R2");
        bus_write_skew('h0ABC, 'h7F000, 'h11, 'h3C, "R2");
        bus_read_pulse('h555, 'hAA);
        bus_read_pulse('h2AA, 'h55);

        // R4 auto select and read array.
        unlock("R4");
        bus_write('h555, 'h90, "R4");
        unlock("R4");
        bus_write('h555, 'hF0, "R4");

        // R8 deviations at each position.
        bus_write('h555, 'h12, "R8");
        bus_write('h555, 'hAA, "R8");
        bus_write('h2AB, 'h55, "R8");
        unlock("R8");
        bus_write('h555, 'h77, "R8");
        unlock("R8");
        bus_write('h554, 'hA0, "R8");
        unlock("R8");
        bus_write('h555, 'h80, "R8");
        bus_write('h555, 'hAB, "R8");

        // R5 chip erase, then R9 suspend/resume, then R10 done.
        erase_pre("R5");
        bus_write('h555, 'h10, "R5");
        bus_write('h100, 'hB0, "R9");
        bus_write('h100, 'hB0, "R9");
        bus_write('h100, 'h30, "R9");
        bus_write('h100, 'h30, "R9");
        pulse_done();
        bus_write('h100, 'hB0, "R10");
        bus_write('h100, 'h30, "R10");
        erase_pre("R5");
        bus_write('h556, 'h10, "R5");

        // R6 block erase and R7 window on both sides of the bound.
        erase_pre("R6");
        bus_write('h30000, 'h30, "R6");
        bus_write('h40000, 'h30, "R7");
        idle(WIN - 5);
        bus_write('h50000, 'h30, "R7");
        idle(WIN - 4);
        bus_write('h60000, 'h30, "R7");
        bus_write('h60000, 'hB0, "R9");
        pulse_done();

        // R11 low supply mid-sequence and during erase.
        unlock("R11");
        pulse_lowv();
        bus_write('h555, 'hA0, "R11");
        erase_pre("R11");
        bus_write('h20000, 'h30, "R11");
        pulse_lowv();
        bus_write('h20000, 'hB0, "R11");

        idle(6);
        vectors++;
        if (q_due.size() != 0) begin
            fails++;
            $display("FAIL R12: %0d expected strobes never seen, expected 0", q_due.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule